// File: doc/BRIEF.md
# FIFO-Buffered Configuration Port Controller

This block is a memory-mapped peripheral that moves 32-bit words between a simple register bus and a word-wide configuration access port. For a configuration write, software fills a 1024-word outbound FIFO through a data register and then issues a drain command. The block then hands the queued words to the port over a valid/ready handshake until the FIFO is empty.

For a readback, software programs a 12-bit word count and issues a fetch command. The block accepts words from the port only while the count is non-zero and the 256-word inbound FIFO has room. Software pops those words through a data register. Free space and fill level are visible as registers, and a done flag reports when no transfer is running.

Four FIFO-level events feed a toggle-to-acknowledge status register. These events are outbound half full, inbound half full, outbound empty and inbound full. The status register is masked by a per-source enable and a global enable to form one interrupt line. A control register can also flush both FIFOs or return the whole block to its reset state.

Top module: `cfgp_ctrl`

## Requirements
- R1: After reset, status reads 1 (bit 0 = done), vacancy reads 1024, occupancy reads 0, the status/enable/global-enable/size/control registers read 0, `irq` is low and neither port handshake signal is asserted.
- R2: A bus write to byte offset 0x100 appends the word to the outbound FIFO unless it holds 1024 words, in which case the write is dropped. Offset 0x114 reads 1024 minus the number of queued words.
- R3: Writing 1 to control (0x10C) bit 0 while idle starts a drain. `port_wr_valid` is high exactly while draining with a non-empty outbound FIFO, and `port_wr_data` is the oldest queued word. A word leaves on each cycle with valid and ready both high. Status bit 0 is 0 from the cycle after the command until the cycle after the FIFO is seen empty.
- R4: Offset 0x108 holds a 12-bit size (bits 11:0; other bits are ignored). Writing control bit 1 while idle loads that count. `port_rd_ready` is high only while fetching with a non-zero count and fewer than 256 inbound words. Each accepted word is queued and decrements the count, and done returns the cycle after the count is seen at zero. Offset 0x118 reads the inbound word count.
- R5: A bus read of offset 0x104 returns and removes the oldest inbound word. When the FIFO is empty, the read returns 0 and changes nothing.
- R6: A start command written while a transfer runs is ignored. If bits 0 and 1 are written together, the drain is started. The control register always reads 0.
- R7: Writing control bit 2 empties both FIFOs at that clock edge.
- R8: Writing control bit 3 returns every register, both FIFOs and the transfer state to their reset values at that clock edge.
- R9: Interrupt status (0x20) has bit 0 = outbound at least half full, bit 1 = inbound at least half full, bit 2 = outbound empty, bit 3 = inbound full. A bit sets one cycle after its condition goes from false to true, and writing 1 to a bit toggles it.
- R10: `irq` equals global enable (bit 31 at 0x1C) AND the OR over the four sources of status AND enable (enable register at 0x28, same bit layout).
- R11: Unused register bits and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe (pops the inbound FIFO at 0x104) |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| port_wr_valid | output | 1 | Outbound word valid toward the port |
| port_wr_ready | input | 1 | Port accepts the outbound word |
| port_wr_data | output | 32 | Outbound word |
| port_rd_ready | output | 1 | Block accepts an inbound word |
| port_rd_valid | input | 1 | Port presents an inbound word |
| port_rd_data | input | 32 | Inbound word |
| irq | output | 1 | Interrupt request |

## Verification
Read data and both port handshake signals are combinational. They are due in the same cycle as the access or state, so the bench compares them 1 ns after the falling edge, against a queue-based model holding the pre-edge state. Register writes, FIFO pushes and pops, and command acceptance take effect at the next rising edge and show in the following cycle. Interrupt status lags the fill-level change by one further cycle, and done rises one cycle after the FIFO is seen empty or the count is seen at zero. The model advances with exactly these latencies and is compared on every cycle, so an early or late result shows up in the cycle it is wrong.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int BUS_AW = 9;
    localparam int BUS_DW = 32;
    localparam int SIZE_W = 12;
    localparam int N_SRC  = 4;

    // register byte offsets
    localparam logic [BUS_AW-1:0] REG_GLB_EN  = 9'h01C;
    localparam logic [BUS_AW-1:0] REG_EVT_STS = 9'h020;
    localparam logic [BUS_AW-1:0] REG_EVT_ENA = 9'h028;
    localparam logic [BUS_AW-1:0] REG_OUT_DAT = 9'h100;
    localparam logic [BUS_AW-1:0] REG_IN_DAT  = 9'h104;
    localparam logic [BUS_AW-1:0] REG_XF_SIZE = 9'h108;
    localparam logic [BUS_AW-1:0] REG_COMMAND = 9'h10C;
    localparam logic [BUS_AW-1:0] REG_STATE   = 9'h110;
    localparam logic [BUS_AW-1:0] REG_OUT_FREE = 9'h114;
    localparam logic [BUS_AW-1:0] REG_IN_LEVEL = 9'h118;

    // command bit positions
    localparam int CMD_DRAIN = 0;
    localparam int CMD_FETCH = 1;
    localparam int CMD_FLUSH = 2;
    localparam int CMD_RESET = 3;

    // event source bit positions
    localparam int EV_OUT_HALF  = 0;
    localparam int EV_IN_HALF   = 1;
    localparam int EV_OUT_EMPTY = 2;
    localparam int EV_IN_FULL   = 3;

    localparam int GLB_EN_BIT = 31;

    // level of each event condition while the block sits in reset
    localparam logic [N_SRC-1:0] EV_RESET_LEVEL = 4'b0100;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_DRAIN = 2'd1,
        XF_FETCH = 2'd2
    } xfer_state_t;

    typedef struct packed {
        logic reset;
        logic flush;
        logic fetch;
        logic drain;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic we, input logic [BUS_DW-1:0] d);
        cmd_t c;
        c.drain = we & d[CMD_DRAIN];
        c.fetch = we & d[CMD_FETCH] & ~d[CMD_DRAIN];
        c.flush = we & d[CMD_FLUSH];
        c.reset = we & d[CMD_RESET];
        return c;
    endfunction

endpackage

// File: rtl/cfgp_fifo.sv
module cfgp_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/cfgp_xfer.sv
module cfgp_xfer
    import cfgp_pkg::*;
#(
    parameter int CNT_W = SIZE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_drain,
    input  logic             go_fetch,
    input  logic [CNT_W-1:0] size,
    input  logic             out_empty,
    input  logic             in_full,
    input  logic             port_wr_ready,
    input  logic             port_rd_valid,
    output logic             port_wr_valid,
    output logic             port_rd_ready,
    output logic             out_pop,
    output logic             in_push,
    output logic             busy
);

    xfer_state_t      state;
    logic [CNT_W-1:0] remain;

    assign port_wr_valid = (state == XF_DRAIN) && !out_empty;
    assign out_pop       = port_wr_valid && port_wr_ready;
    assign port_rd_ready = (state == XF_FETCH) && (remain != '0) && !in_full;
    assign in_push       = port_rd_ready && port_rd_valid;
    assign busy          = (state != XF_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= XF_IDLE;
            remain <= '0;
        end else begin
            case (state)
                XF_IDLE: begin
                    if (go_drain) begin
                        state <= XF_DRAIN;
                    end else if (go_fetch) begin
                        state  <= XF_FETCH;
                        remain <= size;
                    end
                end
                XF_DRAIN: begin
                    if (out_empty) begin
                        state <= XF_IDLE;
                    end
                end
                XF_FETCH: begin
                    if (remain == '0) begin
                        state <= XF_IDLE;
                    end else if (in_push) begin
                        remain <= remain - 1'b1;
                    end
                end
                default: state <= XF_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfgp_irq.sv
module cfgp_irq #(
    parameter int              NSRC        = 4,
    parameter logic [NSRC-1:0] RESET_LEVEL = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] cond,
    input  logic            tog_we,
    input  logic [NSRC-1:0] tog_mask,
    input  logic [NSRC-1:0] enable,
    input  logic            glb_en,
    output logic [NSRC-1:0] status,
    output logic            irq
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic sts_q;
        logic last_q;
        logic flip;
        logic rise;

        assign flip = tog_we & tog_mask[i];
        assign rise = cond[i] & ~last_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sts_q  <= 1'b0;
                last_q <= RESET_LEVEL[i];
            end else begin
                last_q <= cond[i];
                sts_q  <= (sts_q ^ flip) | rise;
            end
        end

        assign status[i] = sts_q;
    end

    assign irq = glb_en & |(status & enable);

endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
    import cfgp_pkg::*;
#(
    parameter int WR_DEPTH = 1024,
    parameter int RD_DEPTH = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr_en,
    input  logic                 bus_rd_en,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    output logic                 port_wr_valid,
    input  logic                 port_wr_ready,
    output logic [BUS_DW-1:0]    port_wr_data,
    output logic                 port_rd_ready,
    input  logic                 port_rd_valid,
    input  logic [BUS_DW-1:0]    port_rd_data,
    output logic                 irq
);

    localparam int WCW = $clog2(WR_DEPTH + 1);
    localparam int RCW = $clog2(RD_DEPTH + 1);

    cmd_t              cmd;
    logic              sw_reset;
    logic              fifo_flush;
    logic              blk_rst;

    logic [N_SRC-1:0]  ena_q;
    logic              glb_q;
    logic [SIZE_W-1:0] size_q;
    logic [N_SRC-1:0]  evt_sts;
    logic [N_SRC-1:0]  evt_cond;

    logic              out_push, out_pop, out_full, out_empty;
    logic [WCW-1:0]    wf_count;
    logic              in_push, in_pop, in_full, in_empty;
    logic [RCW-1:0]    rf_count;
    logic [BUS_DW-1:0] in_head;
    logic              busy;

    assign cmd        = decode_cmd(bus_wr_en && (bus_addr == REG_COMMAND), bus_wdata);
    assign sw_reset   = cmd.reset;
    assign fifo_flush = cmd.flush;
    assign blk_rst    = rst | sw_reset;

    assign out_push = bus_wr_en && (bus_addr == REG_OUT_DAT);
    assign in_pop   = bus_rd_en && (bus_addr == REG_IN_DAT);

    // configuration registers
    always_ff @(posedge clk) begin
        if (blk_rst) begin
            ena_q  <= '0;
            glb_q  <= 1'b0;
            size_q <= '0;
        end else if (bus_wr_en) begin
            case (bus_addr)
                REG_EVT_ENA: ena_q  <= bus_wdata[N_SRC-1:0];
                REG_GLB_EN:  glb_q  <= bus_wdata[GLB_EN_BIT];
                REG_XF_SIZE: size_q <= bus_wdata[SIZE_W-1:0];
                default: ;
            endcase
        end
    end

    cfgp_fifo #(.WIDTH(BUS_DW), .DEPTH(WR_DEPTH)) u_out_fifo (
        .clk   (clk),
        .rst   (blk_rst),
        .clr   (fifo_flush),
        .push  (out_push),
        .wdata (bus_wdata),
        .pop   (out_pop),
        .rdata (port_wr_data),
        .count (wf_count),
        .full  (out_full),
        .empty (out_empty)
    );

    cfgp_fifo #(.WIDTH(BUS_DW), .DEPTH(RD_DEPTH)) u_in_fifo (
        .clk   (clk),
        .rst   (blk_rst),
        .clr   (fifo_flush),
        .push  (in_push),
        .wdata (port_rd_data),
        .pop   (in_pop),
        .rdata (in_head),
        .count (rf_count),
        .full  (in_full),
        .empty (in_empty)
    );

    cfgp_xfer #(.CNT_W(SIZE_W)) u_xfer (
        .clk           (clk),
        .rst           (blk_rst),
        .go_drain      (cmd.drain),
        .go_fetch      (cmd.fetch),
        .size          (size_q),
        .out_empty     (out_empty),
        .in_full       (in_full),
        .port_wr_ready (port_wr_ready),
        .port_rd_valid (port_rd_valid),
        .port_wr_valid (port_wr_valid),
        .port_rd_ready (port_rd_ready),
        .out_pop       (out_pop),
        .in_push       (in_push),
        .busy          (busy)
    );

    always_comb begin
        evt_cond               = '0;
        evt_cond[EV_OUT_HALF]  = (wf_count >= WCW'(WR_DEPTH / 2));
        evt_cond[EV_IN_HALF]   = (rf_count >= RCW'(RD_DEPTH / 2));
        evt_cond[EV_OUT_EMPTY] = out_empty;
        evt_cond[EV_IN_FULL]   = in_full;
    end

    cfgp_irq #(.NSRC(N_SRC), .RESET_LEVEL(EV_RESET_LEVEL)) u_irq (
        .clk      (clk),
        .rst      (blk_rst),
        .cond     (evt_cond),
        .tog_we   (bus_wr_en && (bus_addr == REG_EVT_STS)),
        .tog_mask (bus_wdata[N_SRC-1:0]),
        .enable   (ena_q),
        .glb_en   (glb_q),
        .status   (evt_sts),
        .irq      (irq)
    );

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_GLB_EN:   bus_rdata[GLB_EN_BIT] = glb_q;
            REG_EVT_STS:  bus_rdata[N_SRC-1:0]  = evt_sts;
            REG_EVT_ENA:  bus_rdata[N_SRC-1:0]  = ena_q;
            REG_IN_DAT:   bus_rdata             = in_empty ? '0 : in_head;
            REG_XF_SIZE:  bus_rdata[SIZE_W-1:0] = size_q;
            REG_STATE:    bus_rdata[0]          = ~busy;
            REG_OUT_FREE: bus_rdata             = BUS_DW'(WR_DEPTH) - BUS_DW'(wf_count);
            REG_IN_LEVEL: bus_rdata             = BUS_DW'(rf_count);
            default:      bus_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
    parameter int WR_DEPTH = 1024,
    parameter int RD_DEPTH = 256,
    localparam int WCW = $clog2(WR_DEPTH + 1),
    localparam int RCW = $clog2(RD_DEPTH + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           port_wr_valid,
    input logic           port_rd_ready,
    input logic           irq,
    input logic           glb_q,
    input logic           busy,
    input logic           sw_reset,
    input logic           fifo_flush,
    input logic [WCW-1:0] wf_count,
    input logic [RCW-1:0] rf_count
);

    AST_DRAIN_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        port_wr_valid |-> busy); // R3

    AST_FETCH_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
        port_rd_ready |-> (rf_count < RCW'(RD_DEPTH))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wf_count <= WCW'(WR_DEPTH)); // R2

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> glb_q); // R10

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        $past(fifo_flush) |-> (wf_count == '0 && rf_count == '0)); // R7

    AST_SWRST_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(sw_reset) |-> (!busy && wf_count == '0 && !irq)); // R8

endmodule

bind cfgp_ctrl cfgp_checker #(.WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .port_wr_valid (port_wr_valid),
    .port_rd_ready (port_rd_ready),
    .irq           (irq),
    .glb_q         (glb_q),
    .busy          (busy),
    .sw_reset      (sw_reset),
    .fifo_flush    (fifo_flush),
    .wf_count      (wf_count),
    .rf_count      (rf_count)
);

// File: tb/tb_cfgp_ctrl.sv
`timescale 1ns/1ps
module tb_cfgp_ctrl;

    localparam int WD = 1024;
    localparam int RD = 256;

    localparam logic [8:0] A_GLB  = 9'h01C;
    localparam logic [8:0] A_STS  = 9'h020;
    localparam logic [8:0] A_ENA  = 9'h028;
    localparam logic [8:0] A_OUT  = 9'h100;
    localparam logic [8:0] A_IN   = 9'h104;
    localparam logic [8:0] A_SIZE = 9'h108;
    localparam logic [8:0] A_CMD  = 9'h10C;
    localparam logic [8:0] A_STAT = 9'h110;
    localparam logic [8:0] A_FREE = 9'h114;
    localparam logic [8:0] A_LVL  = 9'h118;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr_en, bus_rd_en;
    logic [8:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        port_wr_valid, port_wr_ready;
    logic [31:0] port_wr_data;
    logic        port_rd_ready, port_rd_valid;
    logic [31:0] port_rd_data;
    logic        irq;

    always #2 clk = ~clk;

    cfgp_ctrl dut (
        .clk(clk), .rst(rst),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_wr_valid(port_wr_valid), .port_wr_ready(port_wr_ready),
        .port_wr_data(port_wr_data),
        .port_rd_ready(port_rd_ready), .port_rd_valid(port_rd_valid),
        .port_rd_data(port_rd_data), .irq(irq)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    int    sink_gap = 0;
    int    src_gap  = 0;
    int    src_n    = 0;
    bit    chk_on   = 0;
    string tag_ovr  = "";

    // reference model state
    logic [31:0] mw[$];
    logic [31:0] mr[$];
    logic [3:0]  m_sts, m_ena, m_prev;
    logic        m_glb;
    logic [11:0] m_size;
    int          m_mode;   // 0 idle, 1 draining, 2 fetching
    int          m_cnt;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic string tag_of(logic [8:0] a);
        case (a)
            A_STAT:        return "R3";
            A_FREE, A_OUT: return "R2";
            A_LVL, A_SIZE: return "R4";
            A_IN:          return "R5";
            A_STS:         return "R9";
            A_ENA, A_GLB:  return "R10";
            A_CMD:         return "R6";
            default:       return "R11";
        endcase
    endfunction

    function automatic logic [31:0] exp_rdata(logic [8:0] a);
        case (a)
            A_GLB:  return {m_glb, 31'b0};
            A_STS:  return {28'b0, m_sts};
            A_ENA:  return {28'b0, m_ena};
            A_IN:   return (mr.size() > 0) ? mr[0] : 32'h0;
            A_SIZE: return {20'b0, m_size};
            A_STAT: return {31'b0, (m_mode == 0)};
            A_FREE: return 32'(WD - mw.size());
            A_LVL:  return 32'(mr.size());
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        mw.delete();
        mr.delete();
        m_sts  = '0;
        m_ena  = '0;
        m_prev = 4'b0100;
        m_glb  = 1'b0;
        m_size = '0;
        m_mode = 0;
        m_cnt  = 0;
    endtask

    task automatic model_next(bit ev_wv, bit ev_rr);
        logic [3:0] cond;
        int wsz = mw.size();
        int rsz = mr.size();
        int pre_mode = m_mode;
        int pre_cnt  = m_cnt;
        logic [11:0] pre_size = m_size;
        cond[0] = (wsz >= WD / 2);
        cond[1] = (rsz >= RD / 2);
        cond[2] = (wsz == 0);
        cond[3] = (rsz == RD);
        if (bus_wr_en && bus_addr == A_STS) m_sts = m_sts ^ bus_wdata[3:0];
        m_sts  = m_sts | (cond & ~m_prev);
        m_prev = cond;
        if (ev_rr && port_rd_valid) begin
            mr.push_back(port_rd_data);
            m_cnt--;
            src_n++;
        end
        if (ev_wv && port_wr_ready) void'(mw.pop_front());
        if (bus_rd_en && bus_addr == A_IN && rsz > 0) void'(mr.pop_front());
        if (bus_wr_en && bus_addr == A_OUT && wsz < WD) mw.push_back(bus_wdata);
        if (pre_mode == 1 && wsz == 0) m_mode = 0;
        if (pre_mode == 2 && pre_cnt == 0) m_mode = 0;
        if (bus_wr_en) begin
            case (bus_addr)
                A_GLB:  m_glb  = bus_wdata[31];
                A_ENA:  m_ena  = bus_wdata[3:0];
                A_SIZE: m_size = bus_wdata[11:0];
                A_CMD: begin
                    if (bus_wdata[2]) begin
                        mw.delete();
                        mr.delete();
                    end
                    if (pre_mode == 0) begin
                        if (bus_wdata[0]) m_mode = 1;
                        else if (bus_wdata[1]) begin
                            m_mode = 2;
                            m_cnt  = int'(pre_size);
                        end
                    end
                    if (bus_wdata[3]) model_reset();
                end
                default: ;
            endcase
        end
    endtask

    task automatic step();
        bit ev_wv, ev_rr;
        cyc++;
        port_wr_ready = (sink_gap < 2) || ((cyc % sink_gap) != 0);
        port_rd_valid = (src_gap < 2) || ((cyc % src_gap) != 0);
        port_rd_data  = 32'hA500_0000 + 32'(src_n);
        #1;
        ev_wv = (m_mode == 1) && (mw.size() > 0);
        ev_rr = (m_mode == 2) && (m_cnt != 0) && (mr.size() < RD);
        if (chk_on) begin
            check("R3", "port_wr_valid", 32'(port_wr_valid), 32'(ev_wv));
            if (ev_wv) check("R3", "port_wr_data", port_wr_data, mw[0]);
            check("R4", "port_rd_ready", 32'(port_rd_ready), 32'(ev_rr));
            check("R10", "irq", 32'(irq), 32'(m_glb && |(m_sts & m_ena)));
            if (bus_rd_en)
                check((tag_ovr != "") ? tag_ovr : tag_of(bus_addr), "bus_rdata",
                      bus_rdata, exp_rdata(bus_addr));
        end
        if (rst) model_reset();
        else     model_next(ev_wv, ev_rr);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(logic [8:0] a, logic [31:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_rd(logic [8:0] a);
        bus_rd_en = 1'b1; bus_addr = a;
        step();
        bus_rd_en = 1'b0;
    endtask

    task automatic rd_tag(logic [8:0] a, string t);
        tag_ovr = t;
        bus_rd(a);
        tag_ovr = "";
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_idle(int limit);
        for (int k = 0; k < limit && m_mode != 0; k++) bus_rd(A_STAT);
        bus_rd(A_STAT);
    endtask

    task automatic read_all(string t);
        rd_tag(A_STAT, t); rd_tag(A_FREE, t); rd_tag(A_LVL, t);
        rd_tag(A_STS, t);  rd_tag(A_ENA, t);  rd_tag(A_GLB, t);
        rd_tag(A_SIZE, t); rd_tag(A_CMD, t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired actual=%0d expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr_en = 0; bus_rd_en = 0; bus_addr = '0; bus_wdata = '0;
        port_wr_ready = 0; port_rd_valid = 0; port_rd_data = '0;
        model_reset();
        @(negedge clk);
        idle(4);
        rst = 1'b0;
        chk_on = 1;

        // R1 reset values, R11 holes
        read_all("R1");
        rd_tag(9'h004, "R11"); rd_tag(9'h124, "R11"); rd_tag(9'h0FC, "R11");

        // R10 enables
        bus_wr(A_ENA, 32'hFFFF_FFFF);
        bus_wr(A_GLB, 32'h7FFF_FFFF);
        rd_tag(A_GLB, "R10"); rd_tag(A_ENA, "R11");
        bus_wr(A_GLB, 32'h8000_0000);

        // R2 push, R3 drain with back-pressure, R6 ignored start
        for (int i = 0; i < 6; i++) bus_wr(A_OUT, 32'h1000 + i);
        rd_tag(A_FREE, "R2");
        sink_gap = 3;
        bus_wr(A_CMD, 32'h1);
        bus_wr(A_CMD, 32'h2);
        rd_tag(A_CMD, "R6");
        wait_idle(100);
        rd_tag(A_STS, "R9");
        bus_wr(A_STS, 32'h4); rd_tag(A_STS, "R9");
        bus_wr(A_STS, 32'h4); rd_tag(A_STS, "R9");
        bus_wr(A_STS, 32'h4);

        // R2 overflow drop, R9 half-full, R7 flush
        for (int i = 0; i < WD + 3; i++) bus_wr(A_OUT, 32'(i * 7));
        rd_tag(A_FREE, "R2");
        rd_tag(A_STS, "R9");
        bus_wr(A_CMD, 32'h4);
        rd_tag(A_FREE, "R7");
        bus_wr(A_STS, {28'b0, m_sts});
        for (int i = 0; i < 10; i++) bus_wr(A_OUT, 32'h2000 + i);
        bus_wr(A_CMD, 32'h1);
        idle(3);
        bus_wr(A_CMD, 32'h4);
        wait_idle(20);
        rd_tag(A_FREE, "R7");

        // R4 size width, R6 priority, short readback, R5 pops
        bus_wr(A_SIZE, 32'hFFFF_F005);
        rd_tag(A_SIZE, "R4");
        src_gap = 2;
        bus_wr(A_CMD, 32'h3);
        wait_idle(20);
        rd_tag(A_LVL, "R6");
        bus_wr(A_CMD, 32'h2);
        wait_idle(100);
        rd_tag(A_LVL, "R4");
        for (int i = 0; i < 7; i++) bus_rd(A_IN);
        rd_tag(A_LVL, "R5");

        // R4 back-pressure when inbound full, R9 full/half events
        bus_wr(A_STS, {28'b0, m_sts});
        bus_wr(A_SIZE, 32'd300);
        src_gap = 0;
        bus_wr(A_CMD, 32'h2);
        idle(280);
        rd_tag(A_LVL, "R4");
        rd_tag(A_STS, "R9");
        for (int i = 0; i < 320; i++) bus_rd(A_IN);
        wait_idle(50);
        rd_tag(A_LVL, "R5");

        // R4 zero-length readback
        bus_wr(A_SIZE, 32'd0);
        bus_wr(A_CMD, 32'h2);
        rd_tag(A_STAT, "R4");
        wait_idle(10);

        // R8 software reset mid-transfer
        bus_wr(A_SIZE, 32'd40);
        for (int i = 0; i < 3; i++) bus_wr(A_OUT, 32'h3000 + i);
        src_gap = 3;
        bus_wr(A_CMD, 32'h2);
        idle(5);
        bus_wr(A_CMD, 32'h8);
        read_all("R8");
        idle(4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule